// File: doc/BRIEF.md
# Asynchronous Bus Region Cycle Generator

This block turns one host request into a complete strobe sequence on an asynchronous external bus region, the kind used to reach a compact-flash card in PIO mode. The host presents an address, write data and a direction flag with a one-cycle start pulse. The block then walks a fixed series of phases: address setup, chip-enable-to-strobe delay, the active strobe, hold and a closing pause. It returns read data and a one-cycle done pulse.

Each phase length is a configuration field counted in timing units. A 2-bit multiplier code sets how many clock periods one unit lasts. Reads and writes have their own strobe-width and hold fields. An optional wait mode keeps the strobe asserted while the card's ready line is low and then adds a programmable tail. A region whose enable bit is clear acknowledges a request at once and drives no strobes. Configuration is assumed stable while a cycle is in flight.

Top module: `xbus_cycle_gen`

## Requirements
- R1: The multiplier code sets the clock periods per timing unit: code 0 gives 4, code 1 gives 1, code 2 gives 2 and code 3 gives 8.
- R2: Within a cycle, chip enable (active low) is high during address setup and during the pause, and low from the strobe delay through the hold. Output enable and write enable are never low together, and neither is low unless chip enable is low.
- R3: The address-setup phase lasts cfg_setup × unit clocks and the strobe-delay phase lasts cfg_ce_dly × unit clocks. A field of 0 removes that phase.
- R4: The strobe lasts (width + 1) × unit clocks, the hold lasts (hold + 1) × unit clocks and the pause lasts (cfg_pause + 1) × unit clocks. A read uses output enable with cfg_rd_width and cfg_rd_hold. A write uses write enable with cfg_wr_width and cfg_wr_hold.
- R5: With cfg_wait_en set, the strobe does not end while the ready input, after a two-flop synchronizer, is low. If ready rises k cycles into the strobe, the base part of the strobe lasts max((width+1)×unit, k+3) clocks. cfg_wait × unit clocks of strobe then follow. With cfg_wait_en clear, ready has no effect on any phase length.
- R6: Read data is captured from the bus at the clock edge that ends the output-enable strobe. It is held on rsp_rdata after the done pulse.
- R7: bus_addr holds the request address for the whole cycle. During a write, bus_data carries the write data while write enable is low.
- R8: When cfg_en is 0, a start produces a done pulse in the next cycle with busy low and all strobes and chip enable high.
- R9: busy is high from the cycle after an accepted start through the last pause cycle. rsp_done is a single-cycle pulse in the following cycle, with busy low. A start while busy is ignored.
- R10: During reset, chip enable, output enable and write enable are high, and busy and rsp_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Region enable |
| cfg_mult | input | 2 | Timing-unit multiplier code |
| cfg_setup | input | FW | Address setup before chip enable, in units |
| cfg_ce_dly | input | FW | Chip enable to strobe delay, in units |
| cfg_rd_width | input | FW | Read strobe width minus one, in units |
| cfg_wr_width | input | FW | Write strobe width minus one, in units |
| cfg_rd_hold | input | FW | Read hold minus one, in units |
| cfg_wr_hold | input | FW | Write hold minus one, in units |
| cfg_pause | input | FW | End pause minus one, in units |
| cfg_wait_en | input | 1 | Ready-driven strobe stretch enable |
| cfg_wait | input | FW | Strobe tail after ready returns, in units |
| req_start | input | 1 | One-cycle request pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rsp_rdata | output | DW | Captured read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Cycle in flight |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_addr | output | AW | External address |
| bus_data | inout | DW | External data |
| bus_ready | input | 1 | Asynchronous ready from the device |

## Verification
A wrong phase state or a timer loaded with the wrong length shows up directly as a strobe or chip-enable edge in the wrong cycle. The bench therefore measures every phase width in clocks on every cycle, and an error is visible within the same bus cycle. A stuck or missing stretch appears as an output-enable width that ignores the cycle in which ready was raised. A wrong capture edge appears as a mismatch on rsp_rdata at the done pulse, which the bench compares with the value it drove while the strobe was low.

// File: rtl/xbus_pkg.sv
// Shared types for the asynchronous bus region cycle generator.
package xbus_pkg;

    // Phase of one external bus cycle, in the order they are run.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_CEDLY,
        PH_STROBE,
        PH_WAITX,
        PH_HOLD,
        PH_PAUSE
    } xbus_phase_e;

    // Clock periods per timing unit for a 2-bit multiplier code.
    function automatic logic [3:0] unit_clocks(input logic [1:0] code);
        case (code)
            2'd0:    unit_clocks = 4'd4;
            2'd1:    unit_clocks = 4'd1;
            2'd2:    unit_clocks = 4'd2;
            default: unit_clocks = 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/xbus_ready_sync.sv
// Two-flop synchronizer for the asynchronous ready input.
// Assumes: the input may change at any time relative to clk; reset value low.
module xbus_ready_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q;

    // Shift the input through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            sync_out <= 1'b0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/xbus_phase_timer.sv
// Down-counter that times one phase.
// Assumes: load carries (phase length - 1); expired is high in the last cycle
// of the phase and stays high while the owner lingers in that phase.
module xbus_phase_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/xbus_cycle_gen.sv
// Strobe sequencer for one asynchronous external bus region.
// Runs setup, strobe delay, strobe (with optional ready stretch and tail),
// hold and pause. Every phase is timed in units scaled by the multiplier code.
// Assumes: configuration is stable while busy; one cycle in flight at a time.
module xbus_cycle_gen
    import xbus_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16,
    parameter int FW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic [1:0]    cfg_mult,
    input  logic [FW-1:0] cfg_setup,
    input  logic [FW-1:0] cfg_ce_dly,
    input  logic [FW-1:0] cfg_rd_width,
    input  logic [FW-1:0] cfg_wr_width,
    input  logic [FW-1:0] cfg_rd_hold,
    input  logic [FW-1:0] cfg_wr_hold,
    input  logic [FW-1:0] cfg_pause,
    input  logic          cfg_wait_en,
    input  logic [FW-1:0] cfg_wait,
    input  logic          req_start,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done,
    output logic          busy,
    output logic          bus_ce_n,
    output logic          bus_oe_n,
    output logic          bus_we_n,
    output logic [AW-1:0] bus_addr,
    inout  wire  [DW-1:0] bus_data,
    input  logic          bus_ready
);
    localparam int CW = FW + 4;

    xbus_phase_e   state_q, state_d;
    logic          fire, done_d, cnt_zero, rdy_s, wr_q, wr_sel, drv_q, ph_strobe;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rdata_q;
    logic [FW-1:0] width_sel, hold_sel;
    logic [CW-1:0] unit, len_d, load_val;

    // Phase length in clocks: (field + extra) scaled by the unit.
    function automatic logic [CW-1:0] span(input logic [FW-1:0] f,
                                           input logic extra,
                                           input logic [CW-1:0] u);
        span = (CW'(f) + CW'(extra)) * u;
    endfunction

    xbus_ready_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_ready),
        .sync_out (rdy_s)
    );

    xbus_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fire),
        .load_val (load_val),
        .expired  (cnt_zero)
    );

    // Direction and direction-dependent fields of the cycle being timed.
    always_comb begin
        unit      = CW'(unit_clocks(cfg_mult));
        wr_sel    = (state_q == PH_IDLE) ? req_write : wr_q;
        width_sel = wr_sel ? cfg_wr_width : cfg_rd_width;
        hold_sel  = wr_sel ? cfg_wr_hold  : cfg_rd_hold;
        ph_strobe = (state_q == PH_STROBE);
    end

    // Next phase, skipping zero-length phases, plus the done request.
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        done_d  = 1'b0;
        case (state_q)
            PH_IDLE: if (req_start) begin
                if (!cfg_en) begin
                    done_d = 1'b1;
                end else begin
                    fire    = 1'b1;
                    state_d = (cfg_setup  != '0) ? PH_SETUP :
                              (cfg_ce_dly != '0) ? PH_CEDLY : PH_STROBE;
                end
            end
            PH_SETUP: if (cnt_zero) begin
                fire    = 1'b1;
                state_d = (cfg_ce_dly != '0) ? PH_CEDLY : PH_STROBE;
            end
            PH_CEDLY: if (cnt_zero) begin
                fire    = 1'b1;
                state_d = PH_STROBE;
            end
            PH_STROBE: if (cnt_zero && !(cfg_wait_en && !rdy_s)) begin
                fire    = 1'b1;
                state_d = (cfg_wait_en && cfg_wait != '0) ? PH_WAITX : PH_HOLD;
            end
            PH_WAITX: if (cnt_zero) begin
                fire    = 1'b1;
                state_d = PH_HOLD;
            end
            PH_HOLD: if (cnt_zero) begin
                fire    = 1'b1;
                state_d = PH_PAUSE;
            end
            PH_PAUSE: if (cnt_zero) begin
                fire    = 1'b1;
                done_d  = 1'b1;
                state_d = PH_IDLE;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // Length of the phase being entered, as a timer load value.
    always_comb begin
        case (state_d)
            PH_SETUP:  len_d = span(cfg_setup,  1'b0, unit);
            PH_CEDLY:  len_d = span(cfg_ce_dly, 1'b0, unit);
            PH_STROBE: len_d = span(width_sel,  1'b1, unit);
            PH_WAITX:  len_d = span(cfg_wait,   1'b0, unit);
            PH_HOLD:   len_d = span(hold_sel,   1'b1, unit);
            PH_PAUSE:  len_d = span(cfg_pause,  1'b1, unit);
            default:   len_d = CW'(1);
        endcase
        load_val = len_d - 1'b1;
    end

    // Phase register, request capture and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PH_IDLE;
            rsp_done <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            wr_q     <= 1'b0;
        end else begin
            state_q  <= state_d;
            rsp_done <= done_d;
            if (state_q == PH_IDLE && fire) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                wr_q    <= req_write;
            end
        end
    end

    // Registered pin controls decoded from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ce_n <= 1'b1;
            bus_oe_n <= 1'b1;
            bus_we_n <= 1'b1;
            drv_q    <= 1'b0;
        end else begin
            bus_ce_n <= !(state_d inside {PH_CEDLY, PH_STROBE, PH_WAITX, PH_HOLD});
            bus_oe_n <= !((state_d inside {PH_STROBE, PH_WAITX}) && !wr_sel);
            bus_we_n <= !((state_d inside {PH_STROBE, PH_WAITX}) &&  wr_sel);
            drv_q    <= (state_d inside {PH_CEDLY, PH_STROBE, PH_WAITX, PH_HOLD}) && wr_sel;
        end
    end

    // Capture read data at the edge that releases output enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if ((state_q inside {PH_STROBE, PH_WAITX}) && state_d == PH_HOLD && !wr_q)
            rdata_q <= bus_data;
    end

    assign busy      = (state_q != PH_IDLE);
    assign bus_addr  = addr_q;
    assign bus_data  = drv_q ? wdata_q : {DW{1'bz}};
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/xbus_cycle_chk.sv
// Temporal checks on the cycle generator's pins, bound into every instance.
module xbus_cycle_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_en,
    input logic          cfg_wait_en,
    input logic          req_start,
    input logic          busy,
    input logic          rsp_done,
    input logic          ce_n,
    input logic          oe_n,
    input logic          we_n,
    input logic [AW-1:0] addr,
    input logic          rdy_s,
    input logic          in_strobe
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n)); // R2
    AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> !ce_n); // R2
    AST_WAIT_HOLDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_strobe && cfg_wait_en && !rdy_s) |=> (!oe_n || !we_n)); // R5
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr)); // R7
    AST_DISABLED_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && !busy && !cfg_en) |=> (rsp_done && ce_n && !busy)); // R8
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && !busy && cfg_en) |=> busy); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!busy && ce_n && oe_n && we_n)); // R9
endmodule

bind xbus_cycle_gen xbus_cycle_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_en      (cfg_en),
    .cfg_wait_en (cfg_wait_en),
    .req_start   (req_start),
    .busy        (busy),
    .rsp_done    (rsp_done),
    .ce_n        (bus_ce_n),
    .oe_n        (bus_oe_n),
    .we_n        (bus_we_n),
    .addr        (bus_addr),
    .rdy_s       (rdy_s),
    .in_strobe   (ph_strobe)
);

// File: tb/xbus_cycle_gen_tb.sv
module xbus_cycle_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int FW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b1, cfg_wait_en = 1'b0;
    logic [1:0] cfg_mult = 2'd1;
    logic [FW-1:0] cfg_setup = '0, cfg_ce_dly = '0, cfg_rd_width = '0, cfg_wr_width = '0;
    logic [FW-1:0] cfg_rd_hold = '0, cfg_wr_hold = '0, cfg_pause = '0, cfg_wait = '0;
    logic req_start = 1'b0, req_write = 1'b0, bus_ready = 1'b1;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, tb_rd_val = '0;
    logic [DW-1:0] rsp_rdata;
    logic rsp_done, busy, bus_ce_n, bus_oe_n, bus_we_n;
    logic [AW-1:0] bus_addr;
    wire  [DW-1:0] bus_data;

    int total = 0;
    int bad = 0;

    assign bus_data = !bus_oe_n ? tb_rd_val : {DW{1'bz}};

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_cycle_gen #(.AW(AW), .DW(DW), .FW(FW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mult(cfg_mult),
        .cfg_setup(cfg_setup), .cfg_ce_dly(cfg_ce_dly),
        .cfg_rd_width(cfg_rd_width), .cfg_wr_width(cfg_wr_width),
        .cfg_rd_hold(cfg_rd_hold), .cfg_wr_hold(cfg_wr_hold),
        .cfg_pause(cfg_pause), .cfg_wait_en(cfg_wait_en), .cfg_wait(cfg_wait),
        .req_start(req_start), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .busy(busy), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_ready(bus_ready)
    );

    function automatic int unit_of(input logic [1:0] code);
        if (code == 2'd0) return 4;
        if (code == 2'd1) return 1;
        if (code == 2'd2) return 2;
        return 8;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One bus cycle: measures every phase at the pins and compares.
    // stretch < 0: ready held high; else ready low until stretch cycles into the strobe.
    task automatic run_tx(input int code, input int su, input int cd, input int rw_w,
                          input int ww, input int rh, input int wh, input int pa,
                          input int wen, input int wt, input int wr, input int stretch);
        int u, n_su, n_cd, n_st, n_ho, n_pa, guard, e_st, base;
        bit seen_ce, seen_st, addr_ok, data_ok;
        logic [AW-1:0] a;
        logic [DW-1:0] wd;
        u = unit_of(code[1:0]);
        a = AW'($urandom);
        wd = DW'($urandom);
        @(negedge clk);
        cfg_mult = code[1:0]; cfg_setup = FW'(su); cfg_ce_dly = FW'(cd);
        cfg_rd_width = FW'(rw_w); cfg_wr_width = FW'(ww);
        cfg_rd_hold = FW'(rh); cfg_wr_hold = FW'(wh); cfg_pause = FW'(pa);
        cfg_wait_en = wen[0]; cfg_wait = FW'(wt);
        bus_ready = (stretch < 0);
        tb_rd_val = DW'($urandom);
        repeat (3) @(negedge clk);
        req_start = 1'b1; req_write = wr[0]; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_start = 1'b0;
        n_su = 0; n_cd = 0; n_st = 0; n_ho = 0; n_pa = 0;
        seen_ce = 0; seen_st = 0; addr_ok = 1; data_ok = 1;
        guard = 0;
        while (!rsp_done && guard < 3000) begin
            if (!busy) addr_ok = 0;
            if (bus_addr != a) addr_ok = 0;
            if (!bus_oe_n || !bus_we_n) begin
                n_st++; seen_st = 1;
                if (wr[0] && (bus_we_n || bus_data != wd)) data_ok = 0;
                if (!wr[0] && bus_oe_n) data_ok = 0;
                if (stretch >= 0 && n_st == stretch + 1) bus_ready = 1'b1;
            end else if (!bus_ce_n) begin
                seen_ce = 1;
                if (seen_st) n_ho++; else n_cd++;
            end else begin
                if (seen_ce) n_pa++; else n_su++;
            end
            guard++;
            @(negedge clk);
        end
        bus_ready = 1'b1;
        if (guard >= 3000) check("R9 done never seen", 0, 1);
        base = ((wr[0] ? ww : rw_w) + 1) * u;
        if (wen != 0) e_st = ((stretch >= 0) ? max2(base, stretch + 3) : base) + wt * u;
        else e_st = base;
        check("R1/R3 setup clocks", n_su, su * u);
        check("R1/R3 ce delay clocks", n_cd, cd * u);
        check("R4/R5 strobe clocks", n_st, e_st);
        check("R4 hold clocks", n_ho, ((wr[0] ? wh : rh) + 1) * u);
        check("R4 pause clocks", n_pa, (pa + 1) * u);
        check("R9 done with busy low", int'(busy), 0);
        check("R7 address held while busy", int'(addr_ok), 1);
        check("R2/R4/R7 strobe type and write data", int'(data_ok), 1);
        if (!wr[0]) check("R6 read data", int'(rsp_rdata), int'(tb_rd_val));
        @(negedge clk);
        check("R9 done single pulse", int'(rsp_done), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] held;
        int dones;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 ce_n in reset", int'(bus_ce_n), 1);
        check("R10 oe_n in reset", int'(bus_oe_n), 1);
        check("R10 we_n in reset", int'(bus_we_n), 1);
        check("R10 busy in reset", int'(busy), 0);
        check("R10 done in reset", int'(rsp_done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every multiplier code with fixed fields, read and write
        for (int c = 0; c < 4; c++) begin
            run_tx(c, 1, 2, 1, 2, 0, 1, 1, 0, 0, 0, -1);
            run_tx(c, 1, 2, 1, 2, 0, 1, 1, 0, 0, 1, -1);
        end
        // R3: zero setup and delay skip their phases
        run_tx(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, -1);
        run_tx(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, -1);
        // R5: stretch longer than the base strobe, with and without tail
        run_tx(1, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 7);
        run_tx(2, 1, 0, 1, 1, 1, 0, 0, 1, 2, 1, 10);
        run_tx(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
        // R5: ready ignored when wait mode is off
        run_tx(1, 0, 0, 0, 0, 0, 0, 0, 0, 3, 0, 9);

        // R8: disabled region
        @(negedge clk);
        cfg_en = 1'b0;
        held = rsp_rdata;
        req_start = 1'b1; req_write = 1'b0;
        @(negedge clk);
        req_start = 1'b0;
        check("R8 disabled done next cycle", int'(rsp_done), 1);
        check("R8 disabled busy low", int'(busy), 0);
        check("R8 disabled no chip enable", int'(bus_ce_n), 1);
        check("R8 disabled no strobe", int'(bus_oe_n & bus_we_n), 1);
        repeat (2) @(negedge clk);
        check("R8 disabled read data untouched", int'(rsp_rdata), int'(held));
        cfg_en = 1'b1;

        // R9: start while busy is ignored
        cfg_mult = 2'd1; cfg_setup = '0; cfg_ce_dly = '0; cfg_rd_width = FW'(5);
        cfg_rd_hold = '0; cfg_pause = '0; cfg_wait_en = 1'b0; bus_ready = 1'b1;
        req_start = 1'b1; req_write = 1'b0; req_addr = AW'(12'h155);
        @(negedge clk);
        req_start = 1'b0;
        repeat (2) @(negedge clk);
        req_start = 1'b1; req_addr = AW'(12'h2AA);
        @(negedge clk);
        req_start = 1'b0;
        check("R9 busy during cycle", int'(busy), 1);
        check("R9 second start ignored", int'(bus_addr), 12'h155);
        dones = 0;
        for (int i = 0; i < 20; i++) begin
            if (rsp_done) dones++;
            @(negedge clk);
        end
        check("R9 one done for one accepted start", dones, 1);

        // Constrained random cycles
        for (int t = 0; t < 40; t++) begin
            int wen;
            int st;
            wen = int'($urandom_range(1, 0));
            st = ($urandom_range(1, 0) == 1) ? int'($urandom_range(12, 0)) : -1;
            run_tx(int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
                   int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
                   int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
                   int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
                   wen, int'($urandom_range(2, 0)), int'($urandom_range(1, 0)), st);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule